// File: doc/BRIEF.md
# Cascadable Nibble Magnitude Comparator

This block compares two unsigned operands and reports the result on three flags: greater, equal and less. The operands are split into 4-bit slices, and each slice goes to its own comparator stage. A stage settles its verdict from its own data whenever the two slices differ. When the slices tie, it takes the verdict handed up by the stage below it. The stages are chained from the least significant slice upwards, and the most significant stage drives the result.

The least significant stage takes three cascade inputs from the block's ports. To compare the operand width alone, drive them as greater-in low, equal-in high and less-in low. To make the block one slice of a wider compare, connect them to the result of another comparator.

Every cascade input combination has a defined result, including the combinations that no correct source produces. A parameterised output register stage holds the three flags so they can be sampled on a clock edge.

Top module: `wide_mag_cmp`

## Requirements
- R1: While `rst_n` is low, all three result outputs are low. With the default output register enabled, the outputs show the verdict for the inputs that were present at the previous rising clock edge.
- R2: When the operands differ, exactly one of `res_gt` and `res_lt` is high, following the unsigned comparison of the full operands. `res_eq` is low. The cascade inputs have no effect.
- R3: Bit 0 of each operand is the least significant and bit NIBBLES*4-1 the most significant. Slice k holds bits 4k+3 down to 4k. The highest-order bit where the operands differ decides the result, so 0x800 is greater than 0x7FF.
- R4: When the operands are equal and `casc_eq_i` is high, the outputs are equal=1, greater=0 and less=0, whatever `casc_gt_i` and `casc_lt_i` are.
- R5: When the operands are equal, `casc_eq_i` is low and exactly one of `casc_gt_i` and `casc_lt_i` is high, that one input is passed to the matching output and the other two outputs are low.
- R6: In a single-stage block, when the operands are equal, `casc_eq_i` is low and both `casc_gt_i` and `casc_lt_i` are high, all three outputs are low.
- R7: In a single-stage block, when the operands are equal and all three cascade inputs are low, `res_gt` and `res_lt` are high and `res_eq` is low.
- R8: In a chain, each stage's three outputs feed the next more significant stage's cascade inputs. The last stage's outputs are the result. Equal operands with one of the two illegal cascade patterns therefore give the R6 result or the R7 result, alternating from stage to stage. With an odd NIBBLES count the result matches the single-stage one. With an even count the two patterns swap results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opa | input | NIBBLES*4 | Operand A, unsigned |
| opb | input | NIBBLES*4 | Operand B, unsigned |
| casc_gt_i | input | 1 | Cascade verdict "greater" from a less significant comparator |
| casc_eq_i | input | 1 | Cascade verdict "equal" from a less significant comparator |
| casc_lt_i | input | 1 | Cascade verdict "less" from a less significant comparator |
| res_gt | output | 1 | Operand A greater than operand B |
| res_eq | output | 1 | Operands equal |
| res_lt | output | 1 | Operand A less than operand B |

## Verification
The data decision and the cascade resolution can both apply to the same stage in the same cycle. This happens when a slice differs while an illegal or overriding cascade pattern arrives from below, or when upper slices tie and a lower slice differs. The bench pairs every 4-bit operand pair with all eight cascade patterns on a single-stage instance. It also drives biased random operands into three- and two-stage instances, so that full ties and single-slice differences are common. A vector with differing operands passes only if the cascade pattern left the output untouched. A tied vector passes only if the output matches the cascade rule, applied once per stage.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

   // One comparator verdict as carried between stages.
   typedef struct packed {
      logic gt;
      logic eq;
      logic lt;
   } verdict_t;

   localparam verdict_t VERDICT_IDLE = '{gt: 1'b0, eq: 1'b0, lt: 1'b0};

endpackage

// File: rtl/nib_cmp_stage.sv
module nib_cmp_stage
   import cmp_pkg::*;
#(
   parameter int STAGE_W = 4
) (
   input  logic [STAGE_W-1:0] slice_a,
   input  logic [STAGE_W-1:0] slice_b,
   input  verdict_t           from_below,
   output verdict_t           to_above
);

   if (STAGE_W < 1) begin : g_bad_width
      $error("nib_cmp_stage: STAGE_W must be at least 1");
   end

   logic found;
   logic data_gt;
   logic data_lt;

   // Scan from the top bit down; the first mismatch settles the slice.
   always_comb begin
      found   = 1'b0;
      data_gt = 1'b0;
      data_lt = 1'b0;
      for (int i = STAGE_W - 1; i >= 0; i--) begin
         if (!found && (slice_a[i] != slice_b[i])) begin
            found   = 1'b1;
            data_gt = slice_a[i];
            data_lt = slice_b[i];
         end
      end
   end

   // On a tie the incoming verdict decides; eq overrides, illegal
   // patterns fold to all-low or gt+lt.
   always_comb begin
      if (found) begin
         to_above.gt = data_gt;
         to_above.eq = 1'b0;
         to_above.lt = data_lt;
      end else begin
         to_above.gt = ~from_below.eq & ~from_below.lt;
         to_above.eq = from_below.eq;
         to_above.lt = ~from_below.eq & ~from_below.gt;
      end
   end

endmodule

// File: rtl/nib_cmp_chain.sv
module nib_cmp_chain
   import cmp_pkg::*;
#(
   parameter int NIBBLES = 3,
   parameter int STAGE_W = 4
) (
   input  logic [NIBBLES*STAGE_W-1:0] wide_a,
   input  logic [NIBBLES*STAGE_W-1:0] wide_b,
   input  verdict_t                   seed,
   output verdict_t                   verdict
);

   if (NIBBLES < 1) begin : g_bad_count
      $error("nib_cmp_chain: NIBBLES must be at least 1");
   end

   verdict_t link [NIBBLES+1];

   assign link[0] = seed;

   for (genvar k = 0; k < NIBBLES; k++) begin : g_stage
      nib_cmp_stage #(
         .STAGE_W (STAGE_W)
      ) u_stage (
         .slice_a    (wide_a[k*STAGE_W +: STAGE_W]),
         .slice_b    (wide_b[k*STAGE_W +: STAGE_W]),
         .from_below (link[k]),
         .to_above   (link[k+1])
      );
   end

   assign verdict = link[NIBBLES];

endmodule

// File: rtl/verdict_reg.sv
module verdict_reg
   import cmp_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  verdict_t d,
   output verdict_t q
);

   if (OUT_REG) begin : g_flop
      verdict_t held;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held <= VERDICT_IDLE;
         end else begin
            held <= d;
         end
      end
      assign q = held;
   end else begin : g_wire
      assign q = rst_n ? d : VERDICT_IDLE;
   end

endmodule

// File: rtl/wide_mag_cmp.sv
module wide_mag_cmp
   import cmp_pkg::*;
#(
   parameter int NIBBLES = 3,
   parameter int STAGE_W = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NIBBLES*STAGE_W-1:0] opa,
   input  logic [NIBBLES*STAGE_W-1:0] opb,
   input  logic                       casc_gt_i,
   input  logic                       casc_eq_i,
   input  logic                       casc_lt_i,
   output logic                       res_gt,
   output logic                       res_eq,
   output logic                       res_lt
);

   localparam int WIDTH      = NIBBLES * STAGE_W;
   localparam bit ODD_CHAIN  = (NIBBLES % 2) == 1;

   if (WIDTH < 1) begin : g_bad_width
      $error("wide_mag_cmp: operand width must be at least 1");
   end

   verdict_t seed_v;
   verdict_t comb_v;
   verdict_t out_v;

   assign seed_v = '{gt: casc_gt_i, eq: casc_eq_i, lt: casc_lt_i};

   nib_cmp_chain #(
      .NIBBLES (NIBBLES),
      .STAGE_W (STAGE_W)
   ) u_chain (
      .wide_a  (opa),
      .wide_b  (opb),
      .seed    (seed_v),
      .verdict (comb_v)
   );

   verdict_reg #(
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (comb_v),
      .q     (out_v)
   );

   assign res_gt = out_v.gt;
   assign res_eq = out_v.eq;
   assign res_lt = out_v.lt;

   if (OUT_REG) begin : g_chk
      logic primed;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) primed <= 1'b0;
         else        primed <= 1'b1;
      end

      // R1
      reset_low_chk: assert property (@(posedge clk)
         !rst_n |-> (!res_gt && !res_eq && !res_lt));

      // R2
      data_decides_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         $past(opa != opb) |->
            (!res_eq && (res_gt == $past(opa > opb)) && (res_lt == $past(opa < opb))));

      // R4
      eq_override_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         $past((opa == opb) && casc_eq_i) |-> (res_eq && !res_gt && !res_lt));

      // R5
      pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         $past((opa == opb) && !casc_eq_i && (casc_gt_i != casc_lt_i)) |->
            (!res_eq && (res_gt == $past(casc_gt_i)) && (res_lt == $past(casc_lt_i))));

      // R6 R8
      both_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         $past((opa == opb) && !casc_eq_i && casc_gt_i && casc_lt_i) |->
            ((ODD_CHAIN && !res_gt && !res_eq && !res_lt) ||
             (!ODD_CHAIN && res_gt && res_lt && !res_eq)));

      // R7 R8
      none_high_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
         $past((opa == opb) && !casc_eq_i && !casc_gt_i && !casc_lt_i) |->
            ((ODD_CHAIN && res_gt && res_lt && !res_eq) ||
             (!ODD_CHAIN && !res_gt && !res_eq && !res_lt)));
   end

endmodule

// File: tb/test_wide_mag_cmp.sv
module test_wide_mag_cmp;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // single stage
   logic [3:0]  s_a, s_b;
   logic [2:0]  s_c;
   logic        s_gt, s_eq, s_lt;
   // three stages
   logic [11:0] m_a, m_b;
   logic [2:0]  m_c;
   logic        m_gt, m_eq, m_lt;
   // two stages
   logic [7:0]  d_a, d_b;
   logic [2:0]  d_c;
   logic        d_gt, d_eq, d_lt;

   wide_mag_cmp #(.NIBBLES(3)) i_wide_mag_cmp (
      .clk(clk), .rst_n(rst_n), .opa(m_a), .opb(m_b),
      .casc_gt_i(m_c[2]), .casc_eq_i(m_c[1]), .casc_lt_i(m_c[0]),
      .res_gt(m_gt), .res_eq(m_eq), .res_lt(m_lt));

   wide_mag_cmp #(.NIBBLES(1)) i_wide_mag_cmp_n1 (
      .clk(clk), .rst_n(rst_n), .opa(s_a), .opb(s_b),
      .casc_gt_i(s_c[2]), .casc_eq_i(s_c[1]), .casc_lt_i(s_c[0]),
      .res_gt(s_gt), .res_eq(s_eq), .res_lt(s_lt));

   wide_mag_cmp #(.NIBBLES(2)) i_wide_mag_cmp_n2 (
      .clk(clk), .rst_n(rst_n), .opa(d_a), .opb(d_b),
      .casc_gt_i(d_c[2]), .casc_eq_i(d_c[1]), .casc_lt_i(d_c[0]),
      .res_gt(d_gt), .res_eq(d_eq), .res_lt(d_lt));

   // Expected verdict {gt,eq,lt}: slices from bit 0 upward, ties take the cascade rule.
   function automatic logic [2:0] expect_v(int n, logic [11:0] a, logic [11:0] b, logic [2:0] c);
      logic [2:0] v = c;
      for (int k = 0; k < n; k++) begin
         int sa = int'(a[k*4 +: 4]);
         int sb = int'(b[k*4 +: 4]);
         if (sa > sb)      v = 3'b100;
         else if (sa < sb) v = 3'b001;
         else if (v[1])    v = 3'b010;
         else              v = {~v[0], 1'b0, ~v[2]};
      end
      return v;
   endfunction

   function automatic string tag_for(int n, logic [11:0] a, logic [11:0] b, logic [2:0] c);
      if (a != b)                          return "R2";
      if (c[1])                            return "R4";
      if (c == 3'b100 || c == 3'b001)      return "R5";
      if (n > 1)                           return "R8";
      if (c == 3'b101)                     return "R6";
      return "R7";
   endfunction

   task automatic check(string req, string who, logic [2:0] got, logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s got gt/eq/lt=%b expected %b", req, who, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [11:0] rnd_partner(logic [11:0] a, int nib);
      int r = int'($urandom % 4);
      logic [11:0] b = a;
      if (r == 2) begin
         int k = int'($urandom % nib);
         logic [3:0] x = 4'($urandom % 15) + 4'd1;
         b[k*4 +: 4] = a[k*4 +: 4] ^ x;
      end else if (r == 3) begin
         b = 12'($urandom);
      end
      return b;
   endfunction

   task automatic check_all();
      check(tag_for(1, {8'h0, s_a}, {8'h0, s_b}, s_c), "single",
            {s_gt, s_eq, s_lt}, expect_v(1, {8'h0, s_a}, {8'h0, s_b}, s_c));
      check(tag_for(3, m_a, m_b, m_c), "triple",
            {m_gt, m_eq, m_lt}, expect_v(3, m_a, m_b, m_c));
      check(tag_for(2, {4'h0, d_a}, {4'h0, d_b}, d_c), "double",
            {d_gt, d_eq, d_lt}, expect_v(2, {4'h0, d_a}, {4'h0, d_b}, d_c));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      s_a = 4'h5; s_b = 4'h5; s_c = 3'b010;
      m_a = 12'h123; m_b = 12'h456; m_c = 3'b000;
      d_a = 8'h00; d_b = 8'h00; d_c = 3'b101;
      repeat (3) @(negedge clk);
      // R1: outputs held low in reset despite active inputs
      check("R1", "single", {s_gt, s_eq, s_lt}, 3'b000);
      check("R1", "triple", {m_gt, m_eq, m_lt}, 3'b000);
      check("R1", "double", {d_gt, d_eq, d_lt}, 3'b000);
      rst_n = 1'b1;
      step();
      // R1: one edge after release the registered verdict appears
      check_all();

      // R3: highest differing bit decides
      m_a = 12'h800; m_b = 12'h7FF; m_c = 3'b001;
      d_a = 8'h10;   d_b = 8'h0F;   d_c = 3'b000;
      s_a = 4'h4;    s_b = 4'h3;    s_c = 3'b011;
      step();
      check("R3", "triple", {m_gt, m_eq, m_lt}, 3'b100);
      check("R3", "double", {d_gt, d_eq, d_lt}, 3'b100);
      check("R3", "single", {s_gt, s_eq, s_lt}, 3'b100);
      m_a = 12'h3FF; m_b = 12'h400; m_c = 3'b100;
      step();
      check("R3", "triple", {m_gt, m_eq, m_lt}, 3'b001);

      // R8: illegal patterns alternate with stage count
      m_a = 12'hABC; m_b = 12'hABC; m_c = 3'b000;
      d_a = 8'h5A;   d_b = 8'h5A;   d_c = 3'b000;
      step();
      check("R8", "triple", {m_gt, m_eq, m_lt}, 3'b101);
      check("R8", "double", {d_gt, d_eq, d_lt}, 3'b000);
      m_c = 3'b101; d_c = 3'b101;
      step();
      check("R8", "triple", {m_gt, m_eq, m_lt}, 3'b000);
      check("R8", "double", {d_gt, d_eq, d_lt}, 3'b101);

      // Exhaustive single stage (R2 R4 R5 R6 R7), random chains alongside.
      for (int v = 0; v < 2048; v++) begin
         logic [11:0] ra;
         logic [11:0] rb;
         s_a = v[3:0]; s_b = v[7:4]; s_c = v[10:8];
         ra = 12'($urandom);
         m_a = ra; m_b = rnd_partner(ra, 3); m_c = 3'($urandom);
         rb = 12'($urandom);
         rb[11:8] = 4'h0;
         d_a = rb[7:0];
         rb = rnd_partner(rb, 2);
         d_b = rb[7:0]; d_c = 3'($urandom);
         step();
         check_all();
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule